// File: doc/BRIEF.md
# Register Window Pointer with Invalid-Window Checking

This block keeps the current window pointer of a windowed integer register file, together with the processor status word that holds it. Every command that moves the pointer is checked against a per-window invalid mask supplied by the surrounding core. Moving into a window whose mask bit is set raises a trap instead of completing the move. The block accepts four commands: allocate a new window (save), release one (restore), return from trap, and a full status-word write. It reports at most one trap per command, as a type code.

The register storage is not part of this block. It only provides the window base index, which is the pointer times sixteen, for the register file to add to its operand addresses. The number of windows is a parameter from 2 to 32. Results appear on the outputs on the clock edge that accepts the command.

Top module: `regwin_ctrl`

## Requirements
- R1: After a synchronous reset the pointer is 0, the supervisor bit is 1, the trap-enable bit is 0, all other status fields are 0, and no trap is signalled.
- R2: A save (cmd_op 0) whose target window is valid sets the pointer to the current value minus one. From window 0 it goes to window NWIN-1.
- R3: A save whose target window has its mask bit set (win_mask bit i guards window i) raises trap code 0x05 and leaves the pointer unchanged.
- R4: A restore (cmd_op 1) whose target window is valid sets the pointer to the current value plus one. From window NWIN-1 it goes to window 0.
- R5: A restore whose target window is masked raises trap code 0x06 and leaves the pointer unchanged.
- R6: A return from trap (cmd_op 2) while the trap-enable bit is 1 raises trap code 0x02 and changes no status bit.
- R7: A return from trap while the trap-enable bit is 0, with a valid target, sets trap-enable to 1, advances the pointer as a restore does, and copies the previous-supervisor bit into the supervisor bit.
- R8: A return from trap while the trap-enable bit is 0, with a masked target, raises trap code 0x06 and still sets trap-enable to 1. The pointer and the supervisor bit stay unchanged.
- R9: A status write (cmd_op 3) whose pointer field is below NWIN loads every field. The field positions are: flags N,Z,V,C at bits 23:20, FPU enable at 12, interrupt level at 11:8, supervisor at 7, previous supervisor at 6, trap enable at 5, pointer at 4:0. All other bits read as 0.
- R10: A status write whose pointer field is NWIN or more raises trap code 0x02 and changes no status bit.
- R11: The window base index always equals the pointer times 16.
- R12: trap_valid is high only in the cycle after a trapping command, and trap_code is 0 otherwise. A cycle without cmd_valid changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 0 save, 1 restore, 2 return from trap, 3 status write |
| wr_data | input | 32 | Status word for a status write |
| win_mask | input | NWIN | Invalid-window mask, bit i for window i |
| status_word | output | 32 | Current status word |
| cwp | output | 5 | Current window pointer |
| base_idx | output | 9 | Window base index, pointer times 16 |
| trap_en | output | 1 | Trap-enable bit |
| sup | output | 1 | Supervisor bit |
| trap_valid | output | 1 | One-cycle trap request |
| trap_code | output | 8 | Trap type, 0 when no trap |

## Verification
The assertions assume that cmd_op is sampled only while cmd_valid is high, and that win_mask is stable and meaningful in the cycle of the command it guards. They also rely on the pointer being below NWIN, which holds because only range-checked writes and wrapping moves load it. The stimulus drives cmd_op and win_mask at the falling edge together with cmd_valid. It only writes pointer values that are legal, or deliberately illegal in the R10 cases. It keeps the mask set to the exact windows each case needs, so every trap and every move is predicted.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int CWP_W  = 5;
  localparam int WORD_W = 32;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    OP_SAVE    = 2'd0,
    OP_RESTORE = 2'd1,
    OP_RETT    = 2'd2,
    OP_WRST    = 2'd3
  } win_op_e;

  localparam logic [CODE_W-1:0] TRAP_NONE = 8'h00;
  localparam logic [CODE_W-1:0] TRAP_ILL  = 8'h02;
  localparam logic [CODE_W-1:0] TRAP_OVF  = 8'h05;
  localparam logic [CODE_W-1:0] TRAP_UNF  = 8'h06;

  // status word field positions
  localparam int FLAG_LO = 20;
  localparam int EF_BIT  = 12;
  localparam int PIL_LO  = 8;
  localparam int S_BIT   = 7;
  localparam int PS_BIT  = 6;
  localparam int ET_BIT  = 5;
endpackage

// File: rtl/regwin_step.sv
// Neighbour window indices with modulo-NWIN wrap.
module regwin_step #(
  parameter int NWIN = 8,
  parameter int CW   = 5
) (
  input  logic [CW-1:0] cur,
  output logic [CW-1:0] dn,
  output logic [CW-1:0] up
);
  localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

  generate
    if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
      // power-of-two count: natural wrap of the low bits
      assign dn = (cur - 1'b1) & LAST;
      assign up = (cur + 1'b1) & LAST;
    end else begin : g_cmp
      assign dn = (cur == '0)   ? LAST : cur - 1'b1;
      assign up = (cur == LAST) ? '0   : cur + 1'b1;
    end
  endgenerate
endmodule

// File: rtl/regwin_state.sv
// Status word register with field-level update controls.
module regwin_state
  import regwin_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_all,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              cwp_we,
  input  logic [CWP_W-1:0]  cwp_new,
  input  logic              et_set,
  input  logic              s_copy,
  output logic [CWP_W-1:0]  cwp_q,
  output logic              et_q,
  output logic              s_q,
  output logic [WORD_W-1:0] word_q
);
  logic [3:0] flags_q;
  logic [3:0] pil_q;
  logic       ef_q;
  logic       ps_q;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^{wr_word[31:24], wr_word[19:13]};

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      pil_q   <= '0;
      ef_q    <= 1'b0;
      s_q     <= 1'b1;
      ps_q    <= 1'b0;
      et_q    <= 1'b0;
      cwp_q   <= '0;
    end else if (wr_all) begin
      flags_q <= wr_word[FLAG_LO+3:FLAG_LO];
      pil_q   <= wr_word[PIL_LO+3:PIL_LO];
      ef_q    <= wr_word[EF_BIT];
      s_q     <= wr_word[S_BIT];
      ps_q    <= wr_word[PS_BIT];
      et_q    <= wr_word[ET_BIT];
      cwp_q   <= wr_word[CWP_W-1:0];
    end else begin
      if (cwp_we) cwp_q <= cwp_new;
      if (et_set) et_q  <= 1'b1;
      if (s_copy) s_q   <= ps_q;
    end
  end

  always_comb begin
    word_q = '0;
    word_q[FLAG_LO+3:FLAG_LO] = flags_q;
    word_q[EF_BIT]            = ef_q;
    word_q[PIL_LO+3:PIL_LO]   = pil_q;
    word_q[S_BIT]             = s_q;
    word_q[PS_BIT]            = ps_q;
    word_q[ET_BIT]            = et_q;
    word_q[CWP_W-1:0]         = cwp_q;
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [NWIN-1:0]   win_mask,
  output logic [WORD_W-1:0] status_word,
  output logic [CWP_W-1:0]  cwp,
  output logic [CWP_W+3:0]  base_idx,
  output logic              trap_en,
  output logic              sup,
  output logic              trap_valid,
  output logic [CODE_W-1:0] trap_code
);
  localparam logic [CWP_W:0] NW_LIM = (CWP_W + 1)'(NWIN);

  logic [CWP_W-1:0]  cwp_dn, cwp_up, cwp_new;
  logic [31:0]       mask_ext;
  logic              cwp_we, et_set, s_copy, wr_all;
  logic              trap_n;
  logic [CODE_W-1:0] code_n;

  always_comb begin
    mask_ext = '0;
    mask_ext[NWIN-1:0] = win_mask;
  end

  regwin_step #(.NWIN(NWIN), .CW(CWP_W)) u_step (
    .cur(cwp), .dn(cwp_dn), .up(cwp_up)
  );

  regwin_state #(.NWIN(NWIN)) u_state (
    .clk(clk), .rst(rst),
    .wr_all(wr_all), .wr_word(wr_data),
    .cwp_we(cwp_we), .cwp_new(cwp_new),
    .et_set(et_set), .s_copy(s_copy),
    .cwp_q(cwp), .et_q(trap_en), .s_q(sup), .word_q(status_word)
  );

  // command decode: one command per cycle, each either moves or traps
  always_comb begin
    cwp_we  = 1'b0;
    cwp_new = cwp;
    et_set  = 1'b0;
    s_copy  = 1'b0;
    wr_all  = 1'b0;
    trap_n  = 1'b0;
    code_n  = TRAP_NONE;
    if (cmd_valid) begin
      unique case (win_op_e'(cmd_op))
        OP_SAVE: begin
          if (mask_ext[cwp_dn]) begin
            trap_n = 1'b1; code_n = TRAP_OVF;
          end else begin
            cwp_we = 1'b1; cwp_new = cwp_dn;
          end
        end
        OP_RESTORE: begin
          if (mask_ext[cwp_up]) begin
            trap_n = 1'b1; code_n = TRAP_UNF;
          end else begin
            cwp_we = 1'b1; cwp_new = cwp_up;
          end
        end
        OP_RETT: begin
          if (trap_en) begin
            trap_n = 1'b1; code_n = TRAP_ILL;
          end else begin
            et_set = 1'b1;
            if (mask_ext[cwp_up]) begin
              trap_n = 1'b1; code_n = TRAP_UNF;
            end else begin
              cwp_we = 1'b1; cwp_new = cwp_up; s_copy = 1'b1;
            end
          end
        end
        OP_WRST: begin
          if ({1'b0, wr_data[CWP_W-1:0]} >= NW_LIM) begin
            trap_n = 1'b1; code_n = TRAP_ILL;
          end else begin
            wr_all = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid <= 1'b0;
      trap_code  <= TRAP_NONE;
    end else begin
      trap_valid <= trap_n;
      trap_code  <= code_n;
    end
  end

  assign base_idx = {cwp, 4'b0000};

  // ---------------- assertions ----------------
  assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_SAVE && mask_ext[cwp_dn])
      |=> (trap_valid && trap_code == TRAP_OVF && $stable(cwp)));

  assert_restore_move_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_RESTORE && !mask_ext[cwp_up])
      |=> (!trap_valid && cwp == $past(cwp_up)));

  assert_rett_ill_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_RETT && trap_en)
      |=> (trap_valid && trap_code == TRAP_ILL && $stable(status_word)));

  assert_rett_unf_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_RETT && !trap_en && mask_ext[cwp_up])
      |=> (trap_valid && trap_code == TRAP_UNF && trap_en
           && $stable(cwp) && $stable(sup)));

  assert_cwp_range_R9: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cwp} < NW_LIM));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (!trap_valid && trap_code == TRAP_NONE && $stable(status_word)));
endmodule

// File: tb/sim_regwin_ctrl.sv
module sim_regwin_ctrl;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] wr_data = '0;
  logic [NW-1:0] win_mask = '0;
  logic [31:0] status_word;
  logic [4:0]  cwp;
  logic [8:0]  base_idx;
  logic        trap_en, sup, trap_valid;
  logic [7:0]  trap_code;

  always #5 clk = ~clk;

  regwin_ctrl #(.NWIN(NW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .wr_data(wr_data), .win_mask(win_mask), .status_word(status_word),
    .cwp(cwp), .base_idx(base_idx), .trap_en(trap_en), .sup(sup),
    .trap_valid(trap_valid), .trap_code(trap_code)
  );

  typedef struct {
    logic [31:0] word;
    logic        tv;
    logic [7:0]  tc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench-side model state
  logic [3:0] m_flags = 0, m_pil = 0;
  logic m_ef = 0, m_s = 1, m_ps = 0, m_et = 0;
  logic [4:0] m_cwp = 0;

  function automatic logic [31:0] mk_word();
    logic [31:0] w = '0;
    w[23:20] = m_flags; w[12] = m_ef; w[11:8] = m_pil;
    w[7] = m_s; w[6] = m_ps; w[5] = m_et; w[4:0] = m_cwp;
    return w;
  endfunction

  function automatic logic [31:0] pack(input logic [3:0] f, input logic ef,
      input logic [3:0] pil, input logic s, input logic ps, input logic et,
      input logic [4:0] c);
    logic [31:0] w = '0;
    w[23:20] = f; w[12] = ef; w[11:8] = pil;
    w[7] = s; w[6] = ps; w[5] = et; w[4:0] = c;
    return w;
  endfunction

  task automatic do_cmd(input bit v, input logic [1:0] op,
                        input logic [31:0] d, input logic [NW-1:0] m,
                        input string tag);
    exp_t e;
    int dn, up;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; wr_data = d; win_mask = m;
    e.tv = 0; e.tc = 8'h00;
    dn = (m_cwp == 0) ? NW - 1 : int'(m_cwp) - 1;
    up = (int'(m_cwp) == NW - 1) ? 0 : int'(m_cwp) + 1;
    if (v) begin
      case (op)
        2'd0: if (m[dn]) begin e.tv = 1; e.tc = 8'h05; end
              else m_cwp = 5'(dn);
        2'd1: if (m[up]) begin e.tv = 1; e.tc = 8'h06; end
              else m_cwp = 5'(up);
        2'd2: if (m_et) begin e.tv = 1; e.tc = 8'h02; end
              else begin
                m_et = 1;
                if (m[up]) begin e.tv = 1; e.tc = 8'h06; end
                else begin m_cwp = 5'(up); m_s = m_ps; end
              end
        default: if (int'(d[4:0]) >= NW) begin e.tv = 1; e.tc = 8'h02; end
              else begin
                m_flags = d[23:20]; m_ef = d[12]; m_pil = d[11:8];
                m_s = d[7]; m_ps = d[6]; m_et = d[5]; m_cwp = d[4:0];
              end
      endcase
    end
    e.word = mk_word();
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare one expected item after every accepted edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (status_word !== e.word || trap_valid !== e.tv || trap_code !== e.tc
          || base_idx !== {e.word[4:0], 4'b0000} || cwp !== e.word[4:0]
          || trap_en !== e.word[5] || sup !== e.word[7]) begin
        bad++;
        $display("FAIL %s: word=%h tv=%0b tc=%h base=%0d exp word=%h tv=%0b tc=%h base=%0d",
                 e.tag, status_word, trap_valid, trap_code, base_idx,
                 e.word, e.tv, e.tc, {e.word[4:0], 4'b0000});
      end
    end
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    total++;
    if (status_word !== 32'h0000_0080 || trap_valid !== 1'b0 || trap_code !== 8'h00
        || base_idx !== 9'd0) begin
      bad++;
      $display("FAIL R1 reset: word=%h tv=%0b tc=%h exp word=00000080 tv=0 tc=00",
               status_word, trap_valid, trap_code);
    end

    do_cmd(1, 2'd0, 0, '0, "R2 save wrap 0->last");
    do_cmd(1, 2'd0, 0, '0, "R2 save step");
    do_cmd(1, 2'd1, 0, '0, "R4 restore step");
    do_cmd(1, 2'd1, 0, '0, "R4 restore wrap last->0");
    do_cmd(1, 2'd0, 0, 6'b100000, "R3 save into masked window");
    do_cmd(1, 2'd1, 0, 6'b000010, "R5 restore into masked window");
    do_cmd(0, 2'd0, 0, 6'b111111, "R12 idle no change");
    do_cmd(1, 2'd3, pack(4'hA, 1, 4'h9, 0, 1, 0, 5'd3), '0, "R9 status write fields");
    do_cmd(1, 2'd0, 0, '0, "R11 base after save");
    do_cmd(1, 2'd2, 0, '0, "R7 rett moves and copies PS");
    do_cmd(1, 2'd2, 0, '0, "R6 rett with traps enabled");
    do_cmd(1, 2'd3, pack(4'h5, 0, 4'h1, 0, 0, 0, 5'd6), '0, "R10 write cwp=NWIN");
    do_cmd(1, 2'd3, pack(4'h5, 0, 4'h1, 0, 0, 0, 5'd31), '0, "R10 write cwp=31");
    do_cmd(1, 2'd3, pack(4'h3, 1, 4'hF, 1, 0, 0, 5'd5), '0, "R9 write cwp=NWIN-1");
    do_cmd(1, 2'd2, 0, 6'b000001, "R8 rett underflow sets ET");
    do_cmd(0, 2'd2, 0, '0, "R12 idle after trap");
    do_cmd(1, 2'd3, pack(4'h0, 0, 4'h0, 1, 0, 0, 5'd5), '0, "R9 rewrite for rett");
    do_cmd(1, 2'd2, 0, '0, "R7 rett wraps and clears S");
    for (int i = 0; i < 2 * NW; i++) begin
      do_cmd(1, 2'd0, 0, '0, "R2 R11 save sweep");
    end
    for (int i = 0; i < NW; i++) begin
      do_cmd(1, 2'd1, 0, 6'(1 << ((i + 2) % NW)), "R4 R5 restore sweep");
    end
    do_cmd(0, 2'd0, 0, '0, "R12 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule